// File: doc/BRIEF.md
# Assignable Bandwidth Counter Configuration Unit

This block holds a bank of hardware event counters and one 64-bit control word that software uses to point any counter at a bandwidth source. The control word names a counter, a 12-bit source tag, a flag that says whether the tag is a class or a monitoring ID, and a 32-bit event-type mask. Software can build the word over several writes. The chosen counter takes on the new settings only on a write that sets the commit bit. A separate run bit decides whether the committed counter counts.

Each cycle may carry one event from the event stream. The event has a source tag, a type vector and an is-class flag. Every counter that is running and whose tag, flag and mask all match the event adds one. A register port, guarded by a feature-enable input, carries writes and reads of the control word. A separate indexed port reads any counter's value. Accesses that are illegal are dropped and raise a fault pulse.

Top module: `bwc_assign_unit`

## Requirements
- R1: After reset the control word reads as zero, every counter reads zero and is stopped with an all-zero configuration, and `fault` is low. `fault` never rises except in the cycle after a register access.
- R2: A write with bit 63 clear updates only the control word (read back whole). No counter's configuration, run state or value changes.
- R3: A write with bit 63 set and bit 62 clear commits bits 47, 43:32 and 31:0 to the counter named in bits 52:48, and stops that counter. At most one counter is committed per write.
- R4: A write with bits 63 and 62 both set commits the same fields and starts the named counter. It then adds 1 in every cycle with `ev_valid` high, `ev_tag` equal to its tag, `ev_is_class` equal to its flag, and `ev_type` sharing at least one set bit with its mask.
- R5: While `feat_en` is low, a read or write raises `fault` in the next cycle and has no effect: the control word is unchanged and a read returns zero.
- R6: A write with any of bits 61:53 or 46:44 set, or with a counter ID not below `NUM_CTR`, is rejected. It raises `fault` in the next cycle, leaves the control word unchanged and commits nothing.
- R7: A commit that changes a counter's tag, flag or mask clears its value to zero in that same clock edge. A commit that leaves these unchanged, even if it changes the run bit, keeps the value.
- R8: A running counter stops at its all-ones value and does not wrap.
- R9: `reg_rdata` shows the control word one cycle after a read with `feat_en` high. `cnt_value` shows the counter chosen by `cnt_sel` combinationally.
- R10: Events that differ from a running counter's configuration in tag, flag or type leave that counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | Feature enable; register access is legal only when high |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_rd | input | 1 | Read strobe for the control word |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after a read |
| fault | output | 1 | One-cycle pulse after an illegal access |
| ev_valid | input | 1 | Event present this cycle |
| ev_tag | input | 12 | Event source tag |
| ev_type | input | 32 | Event type vector |
| ev_is_class | input | 1 | Event tag is a class ID |
| cnt_sel | input | IDX_W | Counter index for the value port |
| cnt_value | output | CTR_W | Value of the selected counter |

## Verification
The assertions assume that register strobes and write data are driven cleanly for whole cycles and are low during reset. They also assume that `cnt_sel` is held steady across a clock edge when a counter's growth is being compared. The bench changes every input only on the falling edge, holds `cnt_sel` while events stream, and never sends an event in the same cycle as a commit. This keeps the no-wrap property and the fault-cause properties within their assumptions. The sweep uses four 4-bit counters, so every counter ID, the ID limit and saturation are all reached.

// File: rtl/bwc_pkg.sv
`timescale 1ns/1ps
package bwc_pkg;
   localparam int WORD_W   = 64;
   localparam int COMMIT_B = 63;
   localparam int RUN_B    = 62;
   localparam int ID_HI    = 52;
   localparam int ID_LO    = 48;
   localparam int ID_FW    = ID_HI - ID_LO + 1;
   localparam int CLS_B    = 47;
   localparam int TAG_HI   = 43;
   localparam int TAG_LO   = 32;
   localparam int TAG_W    = TAG_HI - TAG_LO + 1;
   localparam int MASK_W   = 32;
   localparam logic [WORD_W-1:0] RSVD_BITS = 64'h3FE0_7000_0000_0000;

   typedef struct packed {
      logic              is_class;
      logic [TAG_W-1:0]  tag;
      logic [MASK_W-1:0] mask;
   } slot_cfg_t;

   function automatic slot_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
      slot_cfg_t c;
      c.is_class = w[CLS_B];
      c.tag      = w[TAG_HI:TAG_LO];
      c.mask     = w[MASK_W-1:0];
      return c;
   endfunction
endpackage

// File: rtl/bwc_cfg_port.sv
`timescale 1ns/1ps
module bwc_cfg_port
   import bwc_pkg::*;
#(
   parameter int NUM_CTR = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                feat_en,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [WORD_W-1:0]   reg_wdata,
   output logic [WORD_W-1:0]   reg_rdata,
   output logic                fault,
   output logic [WORD_W-1:0]   stg_q,
   output logic [NUM_CTR-1:0]  commit_vec,
   output slot_cfg_t           commit_cfg,
   output logic                commit_run
);
   localparam logic [ID_FW:0] ID_LIMIT = (ID_FW+1)'(NUM_CTR);

   logic [ID_FW-1:0] wr_id;
   logic             rsvd_clear;
   logic             id_ok;
   logic             wr_ok;
   logic             bad_access;

   assign wr_id      = reg_wdata[ID_HI:ID_LO];
   assign rsvd_clear = ((reg_wdata & RSVD_BITS) == '0);
   assign id_ok      = ({1'b0, wr_id} < ID_LIMIT);
   assign wr_ok      = reg_wr & feat_en & rsvd_clear & id_ok;
   assign bad_access = (reg_wr & ~wr_ok) | (reg_rd & ~feat_en);

   assign commit_cfg = word_to_cfg(reg_wdata);
   assign commit_run = reg_wdata[RUN_B];

   for (genvar k = 0; k < NUM_CTR; k++) begin : g_dec
      assign commit_vec[k] = wr_ok & reg_wdata[COMMIT_B] & (wr_id == ID_FW'(k));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_q     <= '0;
         reg_rdata <= '0;
         fault     <= 1'b0;
      end else begin
         fault <= bad_access;
         if (wr_ok) stg_q <= reg_wdata;
         if (reg_rd) reg_rdata <= feat_en ? stg_q : '0;
      end
   end
endmodule

// File: rtl/bwc_ctr_slot.sv
`timescale 1ns/1ps
module bwc_ctr_slot
   import bwc_pkg::*;
#(
   parameter int CTR_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  slot_cfg_t         new_cfg,
   input  logic              new_run,
   input  logic              ev_valid,
   input  logic [TAG_W-1:0]  ev_tag,
   input  logic [MASK_W-1:0] ev_type,
   input  logic              ev_is_class,
   output logic [CTR_W-1:0]  count
);
   slot_cfg_t        cfg_q;
   logic             run_q;
   logic [CTR_W-1:0] cnt_q;
   logic [CTR_W-1:0] cnt_inc;
   logic             hit;
   logic             cfg_changed;

   assign hit = ev_valid & run_q & (ev_is_class == cfg_q.is_class)
              & (ev_tag == cfg_q.tag) & (|(ev_type & cfg_q.mask));
   assign cfg_changed = commit & (new_cfg != cfg_q);

   if (SATURATE) begin : g_sat
      assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + CTR_W'(1);
   end else begin : g_wrap
      assign cnt_inc = cnt_q + CTR_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
         run_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         if (commit) begin
            cfg_q <= new_cfg;
            run_q <= new_run;
         end
         if (cfg_changed)  cnt_q <= '0;
         else if (hit)     cnt_q <= cnt_inc;
      end
   end

   assign count = cnt_q;
endmodule

// File: rtl/bwc_sel_mux.sv
`timescale 1ns/1ps
module bwc_sel_mux #(
   parameter int N     = 32,
   parameter int W     = 32,
   parameter int IDX_W = 5
) (
   input  logic [N-1:0][W-1:0] vals,
   input  logic [IDX_W-1:0]    sel,
   output logic [W-1:0]        val
);
   if ((1 << IDX_W) == N) begin : g_full
      assign val = vals[sel];
   end else begin : g_part
      localparam logic [IDX_W:0] LIM = (IDX_W+1)'(N);
      always_comb begin
         val = '0;
         for (int k = 0; k < N; k++)
            if ({1'b0, sel} == (IDX_W+1)'(k) && {1'b0, sel} < LIM) val = vals[k];
      end
   end
endmodule

// File: rtl/bwc_assign_unit.sv
`timescale 1ns/1ps
module bwc_assign_unit
   import bwc_pkg::*;
#(
   parameter int NUM_CTR  = 32,
   parameter int CTR_W    = 32,
   parameter bit SATURATE = 1'b1,
   localparam int IDX_W   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                feat_en,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [63:0]         reg_wdata,
   output logic [63:0]         reg_rdata,
   output logic                fault,
   input  logic                ev_valid,
   input  logic [11:0]         ev_tag,
   input  logic [31:0]         ev_type,
   input  logic                ev_is_class,
   input  logic [IDX_W-1:0]    cnt_sel,
   output logic [CTR_W-1:0]    cnt_value
);
   if (NUM_CTR < 1 || NUM_CTR > (1 << ID_FW)) begin : g_bad_num
      $error("NUM_CTR must lie in 1..32");
   end
   if (CTR_W < 1 || CTR_W > 64) begin : g_bad_width
      $error("CTR_W must lie in 1..64");
   end

   logic [WORD_W-1:0]            stg_q;
   logic [NUM_CTR-1:0]           commit_vec;
   slot_cfg_t                    commit_cfg;
   logic                         commit_run;
   logic [NUM_CTR-1:0][CTR_W-1:0] cnt_all;

   bwc_cfg_port #(.NUM_CTR(NUM_CTR)) port_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .feat_en    (feat_en),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .fault      (fault),
      .stg_q      (stg_q),
      .commit_vec (commit_vec),
      .commit_cfg (commit_cfg),
      .commit_run (commit_run)
   );

   for (genvar k = 0; k < NUM_CTR; k++) begin : g_slot
      bwc_ctr_slot #(.CTR_W(CTR_W), .SATURATE(SATURATE)) slot_i (
         .clk         (clk),
         .rst_n       (rst_n),
         .commit      (commit_vec[k]),
         .new_cfg     (commit_cfg),
         .new_run     (commit_run),
         .ev_valid    (ev_valid),
         .ev_tag      (ev_tag),
         .ev_type     (ev_type),
         .ev_is_class (ev_is_class),
         .count       (cnt_all[k])
      );
   end

   bwc_sel_mux #(.N(NUM_CTR), .W(CTR_W), .IDX_W(IDX_W)) mux_i (
      .vals (cnt_all),
      .sel  (cnt_sel),
      .val  (cnt_value)
   );
endmodule

// File: rtl/bwc_assign_chk.sv
`timescale 1ns/1ps
module bwc_assign_chk
   import bwc_pkg::*;
#(
   parameter int NUM_CTR  = 32,
   parameter int CTR_W    = 32,
   parameter bit SATURATE = 1'b1,
   parameter int IDX_W    = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               feat_en,
   input logic               reg_wr,
   input logic               reg_rd,
   input logic [63:0]        reg_wdata,
   input logic               fault,
   input logic [63:0]        stg_q,
   input logic [NUM_CTR-1:0] commit_vec,
   input logic [IDX_W-1:0]   cnt_sel,
   input logic [CTR_W-1:0]   cnt_value
);
   // R5
   dis_access_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr || reg_rd) && !feat_en |=> fault);

   // R6
   rsvd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && feat_en && ((reg_wdata & RSVD_BITS) != '0) |=> fault && $stable(stg_q));

   // R1
   fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr || reg_rd) |=> !fault);

   // R3
   commit_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(commit_vec));

   // R2
   commit_need_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_vec != '0) |-> reg_wr && feat_en && reg_wdata[COMMIT_B]);

   if (SATURATE) begin : g_nowrap
      // R8
      no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(commit_vec) == '0) && $stable(cnt_sel) |-> cnt_value >= $past(cnt_value));
   end
endmodule

bind bwc_assign_unit bwc_assign_chk #(
   .NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .SATURATE(SATURATE), .IDX_W(IDX_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .feat_en    (feat_en),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_wdata  (reg_wdata),
   .fault      (fault),
   .stg_q      (stg_q),
   .commit_vec (commit_vec),
   .cnt_sel    (cnt_sel),
   .cnt_value  (cnt_value)
);

// File: tb/bwc_assign_unit_tb_top.sv
`timescale 1ns/1ps
module bwc_assign_unit_tb_top;
   localparam int N = 4;
   localparam int W = 4;
   localparam int MAXV = (1 << W) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        feat_en = 1'b1;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        fault;
   logic        ev_valid = 1'b0;
   logic [11:0] ev_tag = '0;
   logic [31:0] ev_type = '0;
   logic        ev_is_class = 1'b0;
   logic [1:0]  cnt_sel = '0;
   logic [W-1:0] cnt_value;

   always #2.5 clk = ~clk;

   bwc_assign_unit #(.NUM_CTR(N), .CTR_W(W), .SATURATE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fault(fault),
      .ev_valid(ev_valid), .ev_tag(ev_tag), .ev_type(ev_type), .ev_is_class(ev_is_class),
      .cnt_sel(cnt_sel), .cnt_value(cnt_value)
   );

   int n_run = 0;
   int n_fail = 0;

   logic        m_cls  [N];
   logic [11:0] m_tag  [N];
   logic [31:0] m_mask [N];
   logic        m_run  [N];
   int          m_val  [N];

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(input bit cfg, input bit run, input int id,
                                      input bit cls, input logic [11:0] tag,
                                      input logic [31:0] mask);
      return {cfg, run, 9'b0, 5'(id), cls, 3'b0, tag, mask};
   endfunction

   task automatic wr(input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(output logic [63:0] v, output logic f);
      @(negedge clk);
      reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      v = reg_rdata; f = fault;
   endtask

   task automatic commit(input string req, input int id, input bit cls,
                         input logic [11:0] tag, input logic [31:0] mask, input bit run);
      wr(mk(1'b1, run, id, cls, tag, mask));
      check(req, {63'b0, fault}, 64'd0);
      if (cls != m_cls[id] || tag != m_tag[id] || mask != m_mask[id]) m_val[id] = 0;
      m_cls[id] = cls; m_tag[id] = tag; m_mask[id] = mask; m_run[id] = run;
   endtask

   task automatic events(input logic [11:0] tag, input logic [31:0] typ,
                         input bit cls, input int count);
      for (int i = 0; i < count; i++) begin
         @(negedge clk);
         ev_valid = 1'b1; ev_tag = tag; ev_type = typ; ev_is_class = cls;
         for (int k = 0; k < N; k++)
            if (m_run[k] && m_cls[k] == cls && m_tag[k] == tag && (m_mask[k] & typ) != 0
                && m_val[k] < MAXV)
               m_val[k]++;
      end
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   task automatic check_all(input string req);
      for (int k = 0; k < N; k++) begin
         cnt_sel = 2'(k);
         #1;
         check(req, 64'(cnt_value), 64'(m_val[k]));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] v;
      logic [63:0] saved;
      logic        f;
      for (int k = 0; k < N; k++) begin
         m_cls[k] = 0; m_tag[k] = 0; m_mask[k] = 0; m_run[k] = 0; m_val[k] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 fault", {63'b0, fault}, 64'd0);
      check_all("R1 counters");
      rd(v, f);
      check("R1 word", v, 64'd0);

      // R5 access while feature disabled
      feat_en = 1'b0;
      wr(mk(1, 1, 0, 0, 12'h005, 32'h1));
      check("R5 write fault", {63'b0, fault}, 64'd1);
      rd(v, f);
      check("R5 read fault", {63'b0, f}, 64'd1);
      check("R5 read data", v, 64'd0);
      feat_en = 1'b1;
      rd(v, f);
      check("R5 word unchanged", v, 64'd0);
      check("R5 no fault", {63'b0, f}, 64'd0);
      events(12'h005, 32'h1, 0, 3);
      check_all("R5 no commit");

      // R2 staging only
      wr(mk(0, 1, 2, 1, 12'h123, 32'hF0));
      check("R2 fault", {63'b0, fault}, 64'd0);
      rd(v, f);
      check("R2 read back", v, mk(0, 1, 2, 1, 12'h123, 32'hF0));
      events(12'h123, 32'h10, 1, 2);
      check_all("R2 counters");

      // R4 sweep over all counters
      for (int k = 0; k < N; k++)
         commit("R4 commit", k, k[0], 12'(16 + k), 32'(1) << k, 1);
      rd(v, f);
      check("R9 word after commit", v, mk(1, 1, N-1, 1, 12'(16 + N - 1), 32'(1) << (N-1)));
      for (int k = 0; k < N; k++)
         events(12'(16 + k), 32'(1) << k, k[0], k + 1);
      check_all("R4 counts");
      events(12'h012, 32'hFFFF_FFFF, 0, 1);
      check_all("R4 multi-bit type");

      // R10 mismatching events
      events(12'h010, 32'h1, 1, 2);
      events(12'h015, 32'h2, 1, 2);
      events(12'h010, 32'h2, 0, 2);
      check_all("R10 ignored");

      // R8 saturation
      events(12'h013, 32'h8, 1, 20);
      check_all("R8 saturate");
      cnt_sel = 2'd3; #1;
      check("R8 max", 64'(cnt_value), 64'(MAXV));

      // R7 identical commit keeps value, run change keeps value
      commit("R7 same", 1, 1, 12'h011, 32'h2, 1);
      check_all("R7 kept");
      commit("R3 stop", 1, 1, 12'h011, 32'h2, 0);
      events(12'h011, 32'h2, 1, 3);
      check_all("R3 stopped");
      commit("R7 change", 1, 1, 12'h011, 32'h6, 1);
      check_all("R7 cleared");
      commit("R3 stop0", 0, 0, 12'h010, 32'h1, 0);
      events(12'h010, 32'h1, 0, 3);
      check_all("R3 no count");

      // R6 rejected writes
      rd(saved, f);
      wr(mk(0, 0, 0, 0, 0, 0) | (64'h1 << 55));
      check("R6 high rsvd fault", {63'b0, fault}, 64'd1);
      wr(mk(1, 1, 2, 0, 12'h777, 32'h1) | (64'h1 << 45));
      check("R6 low rsvd fault", {63'b0, fault}, 64'd1);
      wr(mk(1, 1, 7, 0, 12'h777, 32'h1));
      check("R6 id fault", {63'b0, fault}, 64'd1);
      rd(v, f);
      check("R6 word unchanged", v, saved);
      check_all("R6 no commit");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule